// File: doc/BRIEF.md
# Bit-Serial Multiply-Accumulate Engine

This block computes P = A*B + S for unsigned integers in which only the width of A is bounded by the hardware. A is loaded in parallel, up to `MAX_W` bits, along with its actual width m. B, of any length n ≥ 1, and the addend S, of n+m bits, then stream in one bit per beat, least significant bit first. The n+m+1 bits of P stream out in the same order.

The core is a row of `MAX_W` carry-save cells. Each cell keeps a sum bit and a carry bit. On every accepted beat the row adds B-bit × A into its state, emits its lowest bit and shifts down one place. A single serial full adder with a one-bit carry folds the S stream into that emitted bit. The result goes through a one-entry output register.

The input stream has two phases. The first n beats carry a B bit and an S bit each, and the flag `in_last` marks beat n. The next m beats carry only S bits. After those, the block emits the final P bit without taking any input. Both streams use valid/ready. An input beat is taken when `in_valid && in_ready`. `in_ready` is high only while the block still expects input and its output register is empty or being emptied in the same cycle (`out_ready`). Therefore, a stalled consumer stops input consumption within the same cycle.

Top module: `serial_mac`

## Requirements
- R1: `a_load` while idle captures `a_value` and width `a_len`. A width above `MAX_W` is clamped to `MAX_W`. Bits of `a_value` at position m or higher are discarded, so they never affect P.
- R2: `a_load` while `busy` is high has no effect on the operand or width used by the running operation.
- R3: For m in 0..MAX_W and any n ≥ 1, the bits delivered on `out_p` are P = A*B + S, n+m+1 of them, least significant first. `out_last` is high only with the final bit.
- R4: Input beats 1..n carry B and S bits, with `in_last` on beat n. Beats n+1..n+m carry S bits only, and `in_b` is ignored during them. After beat n+m, `in_ready` stays low.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_p` and `out_last` hold and `in_ready` is low.
- R6: `start` in any state clears the carry-save row and the serial carry, drops a pending output bit and begins a new operation. One cycle later `busy` is high, and `out_valid` and `done` are low.
- R7: `done` rises in the cycle after the final bit is accepted, and `busy` falls at the same point. `done` stays high until the next `start`.
- R8: After reset, `busy`, `done`, `out_valid` and `in_ready` are low.
- R9: With m = 0, the block passes S through as an n+1 bit result whose top bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_load | input | 1 | Capture operand A and its width (idle only) |
| a_len | input | LENW | Width m of A, clamped to MAX_W |
| a_value | input | MAX_W | Parallel operand A |
| start | input | 1 | Begin (or restart) an operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation complete |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Input beat accepted when both high |
| in_b | input | 1 | B bit (first n beats) |
| in_s | input | 1 | S bit (all n+m beats) |
| in_last | input | 1 | Marks beat n, the final B bit |
| out_valid | output | 1 | P bit available |
| out_ready | input | 1 | Consumer takes P bit |
| out_p | output | 1 | P bit, LSB first |
| out_last | output | 1 | Marks the final P bit |

## Verification
Each accepted input beat puts its P bit on `out_p` one cycle after the accepting edge. The final P bit follows one cycle after beat n+m is accepted, provided the output register is free. `done` is set at the edge that accepts that final bit. `busy`, `out_valid` and `done` are checked one cycle after `start`. The bench drives inputs on the falling edge. It evaluates both handshakes shortly after that edge, before the next rising edge, and so records each transfer in the cycle it occurs. The sweep covers every A, B and S up to m = 3 and n = 2 with and without random-looking stalls, and adds long-B, clamped-width and mid-operation restart cases.

// File: rtl/serial_mac_pkg.sv
package serial_mac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BODY,
    ST_TAIL,
    ST_FINAL,
    ST_DRAIN
  } mac_state_e;
endpackage

// File: rtl/mac_cell.sv
module mac_cell (
  input  logic a_bit,
  input  logic b_bit,
  input  logic sum_in,
  input  logic carry_in,
  output logic sum_out,
  output logic carry_out
);
  logic pp;
  always_comb begin
    pp        = a_bit & b_bit;
    sum_out   = pp ^ sum_in ^ carry_in;
    carry_out = (pp & sum_in) | (pp & carry_in) | (sum_in & carry_in);
  end
endmodule

// File: rtl/mac_row.sv
module mac_row #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic         b_bit,
  input  logic [W-1:0] a_vec,
  output logic         lsb
);
  logic [W-1:0] sum_q, carry_q;
  logic [W-1:0] fs, fc;

  for (genvar i = 0; i < W; i++) begin : g_cell
    mac_cell u_cell (
      .a_bit    (a_vec[i]),
      .b_bit    (b_bit),
      .sum_in   (sum_q[i]),
      .carry_in (carry_q[i]),
      .sum_out  (fs[i]),
      .carry_out(fc[i])
    );
  end

  assign lsb = fs[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q   <= '0;
      carry_q <= '0;
    end else if (clr) begin
      sum_q   <= '0;
      carry_q <= '0;
    end else if (step) begin
      sum_q   <= fs >> 1;
      carry_q <= fc;
    end
  end

  // R6
  row_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum_q == '0 && carry_q == '0));
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl import serial_mac_pkg::*; #(
  parameter int LENW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [LENW-1:0] m_len,
  input  logic            in_valid,
  input  logic            in_last,
  input  logic            slot_free,
  input  logic            out_taken,
  output logic            in_ready,
  output logic            beat_fire,
  output logic            final_emit,
  output logic            b_en,
  output logic            s_en,
  output logic            busy,
  output logic            done
);
  mac_state_e      st;
  logic [LENW-1:0] cnt;
  logic            done_q;

  always_comb begin
    in_ready   = (st == ST_BODY || st == ST_TAIL) && slot_free && !start;
    beat_fire  = in_ready && in_valid;
    final_emit = (st == ST_FINAL) && slot_free && !start;
    b_en       = (st == ST_BODY);
    s_en       = (st == ST_BODY || st == ST_TAIL);
    busy       = (st != ST_IDLE);
    done       = done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      done_q <= 1'b0;
    end else if (start) begin
      st     <= ST_BODY;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      case (st)
        ST_BODY: if (beat_fire && in_last) begin
          if (m_len == '0) st <= ST_FINAL;
          else begin
            st  <= ST_TAIL;
            cnt <= m_len;
          end
        end
        ST_TAIL: if (beat_fire) begin
          cnt <= cnt - 1'b1;
          if (cnt == LENW'(1)) st <= ST_FINAL;
        end
        ST_FINAL: if (slot_free) st <= ST_DRAIN;
        ST_DRAIN: if (out_taken) begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4
  tail_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TAIL) |-> (cnt != '0 && cnt <= m_len));
  // R7
  done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRAIN && out_taken && !start) |=> (done_q && st == ST_IDLE));
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st == ST_IDLE));
endmodule

// File: rtl/serial_mac.sv
module serial_mac import serial_mac_pkg::*; #(
  parameter  int MAX_W = 64,
  localparam int LENW  = $clog2(MAX_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_load,
  input  logic [LENW-1:0]  a_len,
  input  logic [MAX_W-1:0] a_value,
  input  logic             start,
  output logic             busy,
  output logic             done,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_b,
  input  logic             in_s,
  input  logic             in_last,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_p,
  output logic             out_last
);
  logic [MAX_W-1:0] a_q;
  logic [LENW-1:0]  m_q;
  logic [LENW-1:0]  len_clamp;
  logic [MAX_W-1:0] len_mask;

  always_comb begin
    len_clamp = (a_len > LENW'(MAX_W)) ? LENW'(MAX_W) : a_len;
    for (int i = 0; i < MAX_W; i++) len_mask[i] = (i < int'(len_clamp));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      m_q <= '0;
    end else if (a_load && !busy) begin
      a_q <= a_value & len_mask;
      m_q <= len_clamp;
    end
  end

  logic out_valid_q, out_p_q, out_last_q, k_q;
  logic slot_free, out_taken;
  logic beat_fire, final_emit, b_en, s_en, step;
  logic row_lsb, b_bit, s_bit, p_bit, k_nxt;

  assign slot_free = !out_valid_q || out_ready;
  assign out_taken = out_valid_q && out_ready && out_last_q;

  mac_ctrl #(.LENW(LENW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .m_len     (m_q),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .slot_free (slot_free),
    .out_taken (out_taken),
    .in_ready  (in_ready),
    .beat_fire (beat_fire),
    .final_emit(final_emit),
    .b_en      (b_en),
    .s_en      (s_en),
    .busy      (busy),
    .done      (done)
  );

  always_comb begin
    step  = beat_fire || final_emit;
    b_bit = b_en && in_b;
    s_bit = s_en && in_s;
  end

  mac_row #(.W(MAX_W)) u_row (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start),
    .step (step),
    .b_bit(b_bit),
    .a_vec(a_q),
    .lsb  (row_lsb)
  );

  always_comb begin
    p_bit = row_lsb ^ s_bit ^ k_q;
    k_nxt = (row_lsb & s_bit) | (row_lsb & k_q) | (s_bit & k_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_p_q     <= 1'b0;
      out_last_q  <= 1'b0;
      k_q         <= 1'b0;
    end else if (start) begin
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      k_q         <= 1'b0;
    end else if (step) begin
      out_valid_q <= 1'b1;
      out_p_q     <= p_bit;
      out_last_q  <= final_emit;
      k_q         <= k_nxt;
    end else if (out_ready) begin
      out_valid_q <= 1'b0;
    end
  end

  assign out_valid = out_valid_q;
  assign out_p     = out_p_q;
  assign out_last  = out_last_q;

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !start) |=>
      (out_valid && $stable(out_p) && $stable(out_last)));
  // R2
  a_busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && a_load) |=> ($stable(a_q) && $stable(m_q)));
  // R6
  start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!out_valid && busy && !done));
  // R3
  final_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
    final_emit |-> !row_lsb);
endmodule

// File: tb/tb_serial_mac.sv
module tb_serial_mac;
  localparam int MW   = 4;
  localparam int LENW = $clog2(MW + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_load = 0, start = 0, in_valid = 0, in_b = 0, in_s = 0, in_last = 0, out_ready = 1;
  logic [LENW-1:0] a_len = '0;
  logic [MW-1:0]   a_value = '0;
  logic busy, done, in_ready, out_valid, out_p, out_last;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  serial_mac #(.MAX_W(MW)) dut (
    .clk(clk), .rst_n(rst_n), .a_load(a_load), .a_len(a_len), .a_value(a_value),
    .start(start), .busy(busy), .done(done), .in_valid(in_valid), .in_ready(in_ready),
    .in_b(in_b), .in_s(in_s), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_p(out_p), .out_last(out_last)
  );

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic run_op(input int len_field, input int m, input logic [63:0] a_raw,
                        input logic [63:0] a_exp, input int n, input logic [63:0] b,
                        input logic [63:0] s, input int mode, input bit do_load,
                        input string tag);
    logic [63:0] s_m, expv, pacc;
    int beat, got, cyc, hold;
    bit fin;
    logic held_p;
    s_m  = s & ((64'd1 << (n + m)) - 64'd1);
    expv = a_exp * b + s_m;
    pacc = '0; beat = 0; got = 0; cyc = 0; hold = 0; fin = 0; held_p = 0;
    if (do_load) begin
      a_load = 1; a_len = LENW'(len_field); a_value = a_raw[MW-1:0];
      @(negedge clk);
      a_load = 0;
    end
    start = 1; in_valid = 0;
    @(negedge clk);
    start = 0;
    // R6: restart state one cycle after start
    check(!out_valid && busy && !done, "R6", "state after start",
          {61'd0, out_valid, busy, done}, 64'b010);
    while (!fin && cyc < 400) begin
      in_valid  = (beat < n + m) && !((mode & 1) != 0 && cyc % 3 == 1);
      in_b      = (beat < n) ? b[beat] : 1'b1;  // R4: tail B bit ignored
      in_s      = (beat < n + m) ? s_m[beat] : 1'b0;
      in_last   = (beat == n - 1);
      out_ready = !((mode & 1) != 0 && cyc % 4 == 2);
      if ((mode & 4) != 0 && beat == 1) begin
        a_load = 1; a_value = ~a_raw[MW-1:0]; a_len = LENW'(MW);  // R2
      end else a_load = 0;
      #1;
      if ((mode & 2) != 0 && out_valid && hold < 3) begin
        out_ready = 0;
        #1;
        if (hold > 0) check(out_p == held_p, "R5", "held bit", 64'(out_p), 64'(held_p));
        check(in_ready == 1'b0, "R5", "in_ready under stall", 64'(in_ready), 64'd0);
        held_p = out_p;
        hold++;
      end
      if (in_valid && in_ready) beat++;
      if (out_valid && out_ready) begin
        pacc[got] = out_p;
        if (out_last) fin = 1;
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    a_load = 0; in_valid = 0; out_ready = 1;
    check(fin && got == n + m + 1 && pacc == expv, tag, "product stream", pacc, expv);
    check(got == n + m + 1, "R4", "bit count", 64'(got), 64'(n + m + 1));
    // R7
    check(done && !busy, "R7", "done after final bit", {62'd0, done, busy}, 64'b10);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000 && !finished) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8
    check(!busy && !done && !out_valid && !in_ready, "R8", "reset outputs",
          {60'd0, busy, done, out_valid, in_ready}, 64'd0);

    // R3 / R1 sweep over small widths
    for (int m = 0; m <= 3; m++)
      for (int n = 1; n <= 2; n++)
        for (int a = 0; a < (1 << m); a++)
          for (int b = 0; b < (1 << n); b++)
            for (int s = 0; s < (1 << (n + m)); s++) begin
              logic [63:0] araw;
              araw = 64'(a);
              if (s % 2 == 1) araw = araw | ((64'hF << m) & 64'hF);  // R1 mask
              run_op(m, m, araw, 64'(a), n, 64'(b), 64'(s),
                     ((a + b + s) % 3 == 0) ? 1 : 0, 1, (s % 2 == 1) ? "R1" : "R3");
            end

    run_op(4, 4, 64'hF, 64'hF, 5, 64'h1F, 64'h1FF, 0, 1, "R3");
    run_op(4, 4, 64'hB, 64'hB, 20, 64'hA5C3B, 64'hFFFFFF, 1, 1, "R3");
    run_op(7, 4, 64'h9, 64'h9, 6, 64'h2D, 64'h3FF, 0, 1, "R1");       // clamp to 4
    run_op(0, 0, 64'hF, 64'h0, 3, 64'h5, 64'h6, 0, 1, "R9");
    run_op(0, 0, 64'h0, 64'h0, 4, 64'hF, 64'hF, 1, 1, "R9");
    run_op(3, 3, 64'h5, 64'h5, 4, 64'hD, 64'h7F, 2, 1, "R5");
    run_op(3, 3, 64'h6, 64'h6, 3, 64'h7, 64'h2A, 4, 1, "R2");

    // R6: abort mid-operation with a pending output bit, then restart
    a_load = 1; a_len = 3; a_value = 4'h5;
    @(negedge clk);
    a_load = 0; start = 1;
    @(negedge clk);
    start = 0; in_valid = 1; in_b = 1; in_s = 1; in_last = 0; out_ready = 0;
    @(negedge clk);
    in_valid = 0;
    @(negedge clk);
    run_op(3, 3, 64'h5, 64'h5, 3, 64'h6, 64'h15, 0, 0, "R6");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule